// File: doc/BRIEF.md
# Reference-Timed Frequency Lock Detector

This block decides whether a recovered serial clock runs at the expected rate. A divider outside the block slows the recovered clock down. The block counts the rising edges of that divided clock over a fixed window of reference-clock cycles and compares the total with the count it expects. The expected count and both tolerance bands are fixed when the design is built.

Lock is granted only when two windows in a row fall inside the narrow acquisition band. Once lock is held, it is kept until a single window falls outside the wider holding band. This gap between the two bands gives hysteresis. The lock state also drives a select line. The select line hands loop control to phase tracking while locked, and returns it to frequency acquisition while unlocked.

A rate code names the standard in use. Every supported code uses the same expected count, because the external divider is set so that each supported rate arrives at the same nominal frequency. Codes beyond the supported set can never hold lock.

Top module: `freq_lock_det`

## Requirements
- R1: During reset, and right after it, `lockDet` and `phaseLoopSel` are both low.
- R2: A measurement window lasts exactly WIN_CYC reference cycles, counted from reset release. The outputs can change only on the clock edge that closes a window.
- R3: A window qualifies for acquisition when its edge count n satisfies |n − E| ≤ floor(E·ACQ_PCT/100), with E = WIN_CYC/DIV_BASE. With the defaults, E = 512 and the allowed deviation is 5.
- R4: Lock is declared at the end of the second of two consecutive qualifying windows. A non-qualifying window between them restarts the pairing.
- R5: While locked, lock is kept when |n − E| ≤ floor(E·HOLD_PCT/100), which is 10 with the defaults. Lock is dropped at the end of any window that deviates by more than this.
- R6: `phaseLoopSel` is high exactly while `lockDet` is high. A high value selects phase tracking and a low value selects frequency acquisition.
- R7: Rate codes 0 to NUM_RATES−1 (0 to 5 by default) are supported and all share E. A code of NUM_RATES or above makes every window fail both bands: lock is never gained, and a held lock drops at the next window end.
- R8: After lock is lost, getting it back again takes two new consecutive qualifying windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Crystal reference clock; clocks every register in the block |
| rstN | input | 1 | Active-low asynchronous reset |
| vcoDivClk | input | 1 | Divided recovered clock, asynchronous to refClk |
| rateCode | input | 3 | Selected rate standard |
| lockDet | output | 1 | High while the loop is considered locked |
| phaseLoopSel | output | 1 | High: phase loop in control; low: frequency loop in control |

## Verification
The bench uses the default parameters: a 4096-cycle window and an expected count of 512. With these values the 1% band is ±5 edges and the 2% band is ±10 edges, so both band edges can be reached with whole edge counts. The bench places windows exactly on each edge: deviations of 5 and 6 for acquisition, and 10 and 11 for holding. The window is long enough to fit 523 edges at a seven-cycle spacing, with quiet margins at both ends. Those margins keep each edge's synchronizer delay from pushing it into the neighbouring window.

// File: rtl/fld_pkg.sv
package fld_pkg;
  // strobe from control to datapath
  typedef struct packed {
    logic winEnd;
  } ctlStrobe_t;

  // band result from datapath to control
  typedef struct packed {
    logic acqOk;
    logic holdOk;
  } bandFlags_t;

  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_PEND   = 2'd1,
    ST_LOCK   = 2'd2
  } lockState_t;
endpackage

// File: rtl/fld_datapath.sv
module fld_datapath
  import fld_pkg::*;
#(
  parameter int WIN_CYC     = 4096,
  parameter int DIV_BASE    = 8,
  parameter int ACQ_PCT     = 1,
  parameter int HOLD_PCT    = 2,
  parameter int NUM_RATES   = 6,
  parameter int RATE_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              refClk,
  input  logic              rstN,
  input  logic              vcoDivClk,
  input  logic [RATE_W-1:0] rateCode,
  input  ctlStrobe_t        ctl,
  output bandFlags_t        flags
);
  localparam int CNT_W    = $clog2(WIN_CYC + 1);
  localparam int EXP      = WIN_CYC / DIV_BASE;
  localparam int ACQ_DEV  = EXP * ACQ_PCT / 100;
  localparam int HOLD_DEV = EXP * HOLD_PCT / 100;
  localparam logic [CNT_W-1:0] EXP_C      = CNT_W'(EXP);
  localparam logic [CNT_W-1:0] ACQ_C      = CNT_W'(ACQ_DEV);
  localparam logic [CNT_W-1:0] HOLD_C     = CNT_W'(HOLD_DEV);
  localparam logic [CNT_W-1:0] CNT_MAX    = CNT_W'(WIN_CYC);
  localparam logic [RATE_W-1:0] MAX_CODE  = RATE_W'(NUM_RATES - 1);

  logic [SYNC_STAGES-1:0] syncReg;
  logic                   prevLvl;
  logic                   edgePulse;
  logic [CNT_W-1:0]       edgeCnt;
  logic [CNT_W-1:0]       devAbs;
  logic                   rateOk;

  genvar gi;
  generate
    for (gi = 0; gi < SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge refClk or negedge rstN)
          if (!rstN) syncReg[0] <= 1'b0;
          else       syncReg[0] <= vcoDivClk;
      end else begin : g_next
        always_ff @(posedge refClk or negedge rstN)
          if (!rstN) syncReg[gi] <= 1'b0;
          else       syncReg[gi] <= syncReg[gi-1];
      end
    end
  endgenerate

  always_ff @(posedge refClk or negedge rstN)
    if (!rstN) prevLvl <= 1'b0;
    else       prevLvl <= syncReg[SYNC_STAGES-1];

  assign edgePulse = syncReg[SYNC_STAGES-1] & ~prevLvl;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                           edgeCnt <= '0;
    else if (ctl.winEnd)                 edgeCnt <= '0;
    else if (edgePulse && edgeCnt != CNT_MAX) edgeCnt <= edgeCnt + CNT_W'(1);
  end

  always_comb begin
    devAbs = (edgeCnt >= EXP_C) ? (edgeCnt - EXP_C) : (EXP_C - edgeCnt);
    rateOk = (rateCode <= MAX_CODE);
    flags.acqOk  = rateOk && (devAbs <= ACQ_C);
    flags.holdOk = rateOk && (devAbs <= HOLD_C);
  end
endmodule

// File: rtl/fld_ctrl.sv
module fld_ctrl
  import fld_pkg::*;
#(
  parameter int WIN_CYC = 4096
) (
  input  logic       refClk,
  input  logic       rstN,
  input  bandFlags_t flags,
  output ctlStrobe_t ctl,
  output logic       lockDet,
  output logic       phaseLoopSel
);
  localparam int WIN_W = $clog2(WIN_CYC);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYC - 1);

  logic [WIN_W-1:0] winCnt;
  lockState_t       state, stateNxt;

  always_ff @(posedge refClk or negedge rstN)
    if (!rstN)            winCnt <= '0;
    else if (ctl.winEnd)  winCnt <= '0;
    else                  winCnt <= winCnt + WIN_W'(1);

  assign ctl.winEnd = (winCnt == WIN_LAST);

  always_comb begin
    stateNxt = state;
    if (ctl.winEnd) begin
      unique case (state)
        ST_SEARCH: stateNxt = flags.acqOk  ? ST_PEND : ST_SEARCH;
        ST_PEND:   stateNxt = flags.acqOk  ? ST_LOCK : ST_SEARCH;
        ST_LOCK:   stateNxt = flags.holdOk ? ST_LOCK : ST_SEARCH;
        default:   stateNxt = ST_SEARCH;
      endcase
    end
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state        <= ST_SEARCH;
      lockDet      <= 1'b0;
      phaseLoopSel <= 1'b0;
    end else begin
      state        <= stateNxt;
      lockDet      <= (stateNxt == ST_LOCK);
      phaseLoopSel <= (stateNxt == ST_LOCK);
    end
  end
endmodule

// File: rtl/freq_lock_det.sv
module freq_lock_det
  import fld_pkg::*;
#(
  parameter int WIN_CYC   = 4096,
  parameter int DIV_BASE  = 8,
  parameter int ACQ_PCT   = 1,
  parameter int HOLD_PCT  = 2,
  parameter int NUM_RATES = 6
) (
  input  logic       refClk,
  input  logic       rstN,
  input  logic       vcoDivClk,
  input  logic [2:0] rateCode,
  output logic       lockDet,
  output logic       phaseLoopSel
);
  ctlStrobe_t ctlS;
  bandFlags_t flags;

  fld_datapath #(
    .WIN_CYC(WIN_CYC), .DIV_BASE(DIV_BASE), .ACQ_PCT(ACQ_PCT),
    .HOLD_PCT(HOLD_PCT), .NUM_RATES(NUM_RATES), .RATE_W(3), .SYNC_STAGES(2)
  ) u_dp (
    .refClk(refClk), .rstN(rstN), .vcoDivClk(vcoDivClk),
    .rateCode(rateCode), .ctl(ctlS), .flags(flags)
  );

  fld_ctrl #(.WIN_CYC(WIN_CYC)) u_ctrl (
    .refClk(refClk), .rstN(rstN), .flags(flags), .ctl(ctlS),
    .lockDet(lockDet), .phaseLoopSel(phaseLoopSel)
  );
endmodule

// File: rtl/fld_checker.sv
module fld_checker #(
  parameter int NUM_RATES = 6
) (
  input logic       refClk,
  input logic       rstN,
  input logic [2:0] rateCode,
  input logic       winEnd,
  input logic       acqOk,
  input logic       holdOk,
  input logic       lockDet,
  input logic       phaseLoopSel
);
  // R2
  window_gap_chk: assert property (@(posedge refClk) disable iff (!rstN)
    winEnd |=> !winEnd);

  // R2
  lock_rise_at_end_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockDet) |-> $past(winEnd));

  // R5
  lock_fall_at_end_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $fell(lockDet) |-> $past(winEnd));

  // R5
  band_nest_chk: assert property (@(posedge refClk) disable iff (!rstN)
    acqOk |-> holdOk);

  // R7
  bad_rate_no_lock_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(lockDet) |-> ($past(rateCode) < 3'(NUM_RATES)));

  // R6
  sel_follow_chk: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(phaseLoopSel) |-> $rose(lockDet));
endmodule

bind freq_lock_det fld_checker #(.NUM_RATES(NUM_RATES)) u_chk (
  .refClk(refClk), .rstN(rstN), .rateCode(rateCode),
  .winEnd(ctlS.winEnd), .acqOk(flags.acqOk), .holdOk(flags.holdOk),
  .lockDet(lockDet), .phaseLoopSel(phaseLoopSel)
);

// File: tb/freq_lock_det_bench.sv
`timescale 1ns/1ps
module freq_lock_det_bench;
  localparam int WIN = 4096;
  localparam int EXPN = 512;

  logic refClk = 1'b0;
  logic rstN = 1'b0;
  logic vcoDivClk = 1'b0;
  logic [2:0] rateCode = 3'd0;
  logic lockDet, phaseLoopSel;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit mLock = 0, mPend = 0;
  int qN[$];
  int qCode[$];
  bit running = 0;

  always #4 refClk = ~refClk;

  freq_lock_det #(.WIN_CYC(WIN), .DIV_BASE(8), .ACQ_PCT(1), .HOLD_PCT(2),
                  .NUM_RATES(6)) u_freq_lock_det (
    .refClk(refClk), .rstN(rstN), .vcoDivClk(vcoDivClk), .rateCode(rateCode),
    .lockDet(lockDet), .phaseLoopSel(phaseLoopSel));

  task automatic check(input bit act, input bit expv, input string tag);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, expv, cyc);
    end
  endtask

  // behavioural reference: evaluated at every window close
  always @(posedge refClk) begin
    if (rstN) begin
      cyc = cyc + 1;
      if (cyc % WIN == 0 && qN.size() > 0) begin
        int n, code, dev;
        bit good, keep;
        n = qN.pop_front();
        code = qCode.pop_front();
        dev = (n > EXPN) ? n - EXPN : EXPN - n;
        good = (code < 6) && (dev <= 5);
        keep = (code < 6) && (dev <= 10);
        if (mLock) begin
          if (!keep) begin mLock = 0; mPend = 0; end
        end else if (good) begin
          if (mPend) begin mLock = 1; mPend = 0; end
          else mPend = 1;
        end else mPend = 0;
      end
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge refClk) begin
    if (running) begin
      check(lockDet, mLock, "R2 lockDet vs model");
      check(phaseLoopSel, mLock, "R6 phaseLoopSel vs model");
    end
  end

  task automatic run_window(input int n, input int code);
    qN.push_back(n);
    qCode.push_back(code);
    for (int c = 0; c < WIN; c++) begin
      @(negedge refClk);
      if (c == 0) rateCode = 3'(code);
      vcoDivClk = (c >= 16) && (c < 16 + 7 * n) && (((c - 16) % 7) < 3);
    end
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge refClk);
    check(lockDet, 1'b0, "R1 lockDet in reset");
    check(phaseLoopSel, 1'b0, "R1 phaseLoopSel in reset");
    rstN = 1'b1;
    running = 1;
    run_window(512, 0);
    check(lockDet, 1'b0, "R4 one good window only");
    run_window(512, 0);
    @(negedge refClk);
    check(lockDet, 1'b1, "R4 locked after two good windows");
    check(phaseLoopSel, 1'b1, "R6 phase loop selected");
    run_window(521, 1);
    run_window(502, 1);
    @(negedge refClk);
    check(lockDet, 1'b1, "R5 deviation 10 holds");
    run_window(523, 1);
    @(negedge refClk);
    check(lockDet, 1'b0, "R5 deviation 11 drops");
    check(phaseLoopSel, 1'b0, "R6 frequency loop selected");
    run_window(517, 2);
    run_window(506, 2);
    @(negedge refClk);
    check(lockDet, 1'b0, "R3 deviation 6 rejected");
    run_window(507, 2);
    run_window(517, 2);
    @(negedge refClk);
    check(lockDet, 1'b1, "R3 deviation 5 accepted");
    run_window(512, 6);
    @(negedge refClk);
    check(lockDet, 1'b0, "R7 code 6 drops lock");
    run_window(512, 7);
    run_window(512, 7);
    @(negedge refClk);
    check(lockDet, 1'b0, "R7 code 7 never locks");
    run_window(512, 3);
    run_window(512, 5);
    @(negedge refClk);
    check(lockDet, 1'b1, "R7 codes 3 and 5 share count");
    run_window(0, 5);
    @(negedge refClk);
    check(lockDet, 1'b0, "R5 no edges drops lock");
    run_window(512, 4);
    @(negedge refClk);
    check(lockDet, 1'b0, "R8 relock needs two windows");
    run_window(512, 4);
    @(negedge refClk);
    check(lockDet, 1'b1, "R8 relock after second window");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule